// File: doc/BRIEF.md
# ADC Power-Up Timing Sequencer

The sequencer steps an external successive-approximation converter through one conversion for each request. It raises the converter's power-enable line and waits for the supply to settle. It then holds the converter's active-low reset for a programmed time, issues a one-cycle start strobe and keeps a sample window open for a programmed number of cycles. After that it waits for the converter's done indication. When the conversion ends, power is held for a programmed standby delay so that a quick follow-up request can reuse the powered converter. The converter is powered down only when that delay expires with no new request.

A two-bit power-mode input decides who owns the power line. With bit 1 clear, the sequencer drives power itself. With bit 1 set, bit 0 forces power on or off. Forcing power on removes the settle phase. Forcing power off holds the sequencer in idle and ignores requests.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, pwrEn, convStart, sampleEn, seqBusy and seqDone are 0 and convRstN is 1.
- R2: In sequencer-owned mode (pwrMode[1]=0), a request in idle sets pwrEn and seqBusy. pwrEn is then held for startWait+1 cycles before the reset phase begins, and pwrEn returns to 0 once the sequencer is back in idle.
- R3: In the reset phase, convRstN is low for rstWait+1 consecutive cycles. convStart is high for exactly one cycle directly after that.
- R4: sampleEn is high for sampleCycles consecutive cycles directly after convStart. A value of 0 is treated as 1.
- R5: After the sample phase the sequencer waits for convDone. seqDone is high in the cycle in which convDone is accepted.
- R6: After the conversion, seqBusy stays high for standbyWait+1 cycles and then falls.
- R7: A request during the standby delay goes straight back to the reset phase, and pwrEn stays high throughout.
- R8: With pwrMode=2'b11, pwrEn is 1 in every state, including idle, and a request goes directly to the reset phase with no settle phase.
- R9: With pwrMode=2'b10, pwrEn is 0 and requests are ignored. Entering this mode in the middle of a sequence returns the sequencer to idle (seqBusy 0) at the next clock edge.
- R10: Every wait count is WAIT_W (default 8) bits wide. A count of 0 gives a phase of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrMode | input | 2 | Bit 1: 0 sequencer owns power, 1 software owns it; bit 0: forced level in software mode |
| startWait | input | WAIT_W | Power settle count |
| rstWait | input | WAIT_W | Reset-to-start count |
| standbyWait | input | WAIT_W | Delay before power-down |
| sampleCycles | input | SMP_W | Sample phase length, 1 to 7 (0 acts as 1) |
| convReq | input | 1 | Conversion request |
| convDone | input | 1 | Converter reports end of conversion |
| pwrEn | output | 1 | Converter power enable |
| convRstN | output | 1 | Active-low converter reset |
| convStart | output | 1 | One-cycle start strobe |
| sampleEn | output | 1 | High during the sample phase |
| seqBusy | output | 1 | High whenever the sequencer is not idle |
| seqDone | output | 1 | High in the cycle a conversion completes |

## Verification
The bench issues single requests under several settings and measures the length of every phase at the pins. One run uses mid-range counts, which separates each count from its neighbours. One run uses all-zero counts to expose off-by-one errors in the count-plus-one rule. Sample lengths of 0 and 7 exercise the lower clamp and the full field. Further runs cover forced-on mode, where the settle phase must vanish and power must stay up in idle, and forced-off mode, both at rest and mid-sequence. A final run places a request inside a long standby delay, which shows whether power is kept and the settle phase is skipped.

// File: rtl/adc_pwr_seq_pkg.sv
package adc_pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR_UP,
    ST_RESET,
    ST_START,
    ST_SAMPLE,
    ST_CONVERT,
    ST_STANDBY
  } seqState_e;

  typedef enum logic [1:0] {
    SEL_SETTLE,
    SEL_RST,
    SEL_SAMPLE,
    SEL_STANDBY
  } cntSel_e;

  // strobe bundle from control to datapath
  typedef struct packed {
    logic    load;
    cntSel_e sel;
  } cntCmd_t;

endpackage

// File: rtl/adc_pwr_seq_dp.sv
module adc_pwr_seq_dp
  import adc_pwr_seq_pkg::*;
#(
  parameter int unsigned WAIT_W = 8,
  parameter int unsigned SMP_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntCmd_t           cmd,
  input  logic [WAIT_W-1:0] startWait,
  input  logic [WAIT_W-1:0] rstWait,
  input  logic [WAIT_W-1:0] standbyWait,
  input  logic [SMP_W-1:0]  sampleCycles,
  output logic              cntZero
);

  localparam logic [WAIT_W-1:0] CNT_ZERO = '0;

  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] loadVal;
  logic [WAIT_W-1:0] sampleLoad;

  // a sample length of 0 behaves as 1
  assign sampleLoad = (sampleCycles == '0) ? CNT_ZERO
                                           : WAIT_W'(sampleCycles - 1'b1);

  always_comb begin
    case (cmd.sel)
      SEL_SETTLE:  loadVal = startWait;
      SEL_RST:     loadVal = rstWait;
      SEL_SAMPLE:  loadVal = sampleLoad;
      default:     loadVal = standbyWait;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= CNT_ZERO;
    else if (cmd.load)      cnt <= loadVal;
    else if (cnt != CNT_ZERO) cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == CNT_ZERO);

  AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && cnt != CNT_ZERO) |=> (cnt == $past(cnt) - 1'b1)); // R10

  AST_CNT_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && cmd.sel == SEL_RST) |=> (cnt == $past(rstWait))); // R3

endmodule

// File: rtl/adc_pwr_seq_ctrl.sv
module adc_pwr_seq_ctrl
  import adc_pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwrMode,
  input  logic       convReq,
  input  logic       convDone,
  input  logic       cntZero,
  output cntCmd_t    cmd,
  output logic       pwrEn,
  output logic       convRstN,
  output logic       convStart,
  output logic       sampleEn,
  output logic       seqBusy,
  output logic       seqDone
);

  seqState_e state, nxt;
  logic swOwned, swOff, swOn;

  assign swOwned = pwrMode[1];
  assign swOff   = swOwned & ~pwrMode[0];
  assign swOn    = swOwned &  pwrMode[0];

  always_comb begin
    nxt = state;
    cmd = '{load: 1'b0, sel: SEL_SETTLE};
    if (swOff) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (convReq) begin
          if (swOn) begin
            nxt = ST_RESET;  cmd = '{load: 1'b1, sel: SEL_RST};
          end else begin
            nxt = ST_PWR_UP; cmd = '{load: 1'b1, sel: SEL_SETTLE};
          end
        end
        ST_PWR_UP: if (cntZero) begin
          nxt = ST_RESET; cmd = '{load: 1'b1, sel: SEL_RST};
        end
        ST_RESET: if (cntZero) nxt = ST_START;
        ST_START: begin
          nxt = ST_SAMPLE; cmd = '{load: 1'b1, sel: SEL_SAMPLE};
        end
        ST_SAMPLE: if (cntZero) nxt = ST_CONVERT;
        ST_CONVERT: if (convDone) begin
          nxt = ST_STANDBY; cmd = '{load: 1'b1, sel: SEL_STANDBY};
        end
        ST_STANDBY: begin
          if (convReq) begin
            nxt = ST_RESET; cmd = '{load: 1'b1, sel: SEL_RST};
          end else if (cntZero) begin
            nxt = ST_IDLE;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign pwrEn     = swOwned ? pwrMode[0] : (state != ST_IDLE);
  assign convRstN  = (state != ST_RESET);
  assign convStart = (state == ST_START);
  assign sampleEn  = (state == ST_SAMPLE);
  assign seqBusy   = (state != ST_IDLE);
  assign seqDone   = (state == ST_CONVERT) && convDone && !swOff;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R3

  AST_START_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(!convRstN)); // R3

  AST_SAMPLE_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleEn) |-> $past(convStart)); // R4

  AST_OFF_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    swOff |=> (state == ST_IDLE)); // R9

  AST_STANDBY_REQ_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && convReq && !swOff) |=> !convRstN); // R7

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_seq_pkg::*;
#(
  parameter int unsigned WAIT_W = 8,
  parameter int unsigned SMP_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwrMode,
  input  logic [WAIT_W-1:0] startWait,
  input  logic [WAIT_W-1:0] rstWait,
  input  logic [WAIT_W-1:0] standbyWait,
  input  logic [SMP_W-1:0]  sampleCycles,
  input  logic              convReq,
  input  logic              convDone,
  output logic              pwrEn,
  output logic              convRstN,
  output logic              convStart,
  output logic              sampleEn,
  output logic              seqBusy,
  output logic              seqDone
);

  cntCmd_t cmd;
  logic    cntZero;

  adc_pwr_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrMode   (pwrMode),
    .convReq   (convReq),
    .convDone  (convDone),
    .cntZero   (cntZero),
    .cmd       (cmd),
    .pwrEn     (pwrEn),
    .convRstN  (convRstN),
    .convStart (convStart),
    .sampleEn  (sampleEn),
    .seqBusy   (seqBusy),
    .seqDone   (seqDone)
  );

  adc_pwr_seq_dp #(.WAIT_W(WAIT_W), .SMP_W(SMP_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .startWait    (startWait),
    .rstWait      (rstWait),
    .standbyWait  (standbyWait),
    .sampleCycles (sampleCycles),
    .cntZero      (cntZero)
  );

endmodule

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pwrMode = 2'b00;
  logic [7:0] startWait = '0, rstWait = '0, standbyWait = '0;
  logic [2:0] sampleCycles = 3'd1;
  logic       convReq = 1'b0, convDone = 1'b0;
  logic       pwrEn, convRstN, convStart, sampleEn, seqBusy, seqDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pwr_seq u0 (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .startWait(startWait),
    .rstWait(rstWait), .standbyWait(standbyWait), .sampleCycles(sampleCycles),
    .convReq(convReq), .convDone(convDone), .pwrEn(pwrEn), .convRstN(convRstN),
    .convStart(convStart), .sampleEn(sampleEn), .seqBusy(seqBusy), .seqDone(seqDone)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic setWaits(int sw, int rw, int bw, int sc);
    startWait = 8'(sw); rstWait = 8'(rw); standbyWait = 8'(bw); sampleCycles = 3'(sc);
  endtask

  // one request, phase lengths measured at the pins, converter modelled inline
  task automatic runSeq(string tag, int ePu, int eRst, int eSmp, int eStb);
    int pu = 0, puOn = 0, rs = 0, st = 0, sm = 0, sb = 0, cv = 0;
    bit done = 0, dn = 0;
    @(negedge clk) convReq = 1'b1;
    @(negedge clk) convReq = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (!seqBusy) break;
      if (done) sb++;
      else if (!convRstN) rs++;
      else if (convStart) st++;
      else if (sampleEn) sm++;
      else if (sm == 0) begin pu++; if (pwrEn) puOn++; end
      else begin
        cv++;
        if (cv == 3) begin convDone = 1'b1; #1; dn = seqDone; done = 1'b1; end
      end
      @(negedge clk); convDone = 1'b0;
    end
    chk({"R2 settle ", tag}, pu, ePu);
    chk({"R2 pwr during settle ", tag}, puOn, ePu);
    chk({"R3 reset len ", tag}, rs, eRst);
    chk({"R3 start strobes ", tag}, st, 1);
    chk({"R4 sample len ", tag}, sm, eSmp);
    chk({"R5 done seen ", tag}, int'(dn), 1);
    chk({"R6 standby len ", tag}, sb, eStb);
  endtask

  task automatic finishConv();
    int n = 0;
    convDone = 1'b1;
    while (seqBusy && n < 2000) begin @(negedge clk); n++; end
    convDone = 1'b0;
    chk("R6 sequence ends", int'(seqBusy), 0);
  endtask

  task automatic testReset();
    chk("R1 pwrEn", int'(pwrEn), 0);
    chk("R1 convRstN", int'(convRstN), 1);
    chk("R1 convStart", int'(convStart), 0);
    chk("R1 sampleEn", int'(sampleEn), 0);
    chk("R1 seqBusy", int'(seqBusy), 0);
    chk("R1 seqDone", int'(seqDone), 0);
  endtask

  task automatic testAuto();
    pwrMode = 2'b00; setWaits(3, 2, 4, 3);
    runSeq("auto", 4, 3, 3, 5);
    chk("R2 power off in idle", int'(pwrEn), 0);
  endtask

  task automatic testZero();
    pwrMode = 2'b00; setWaits(0, 0, 0, 1);
    runSeq("R10 zero counts", 1, 1, 1, 1);
  endtask

  task automatic testSampleEdges();
    setWaits(1, 1, 1, 0);
    runSeq("R4 sample zero", 2, 2, 1, 2);
    setWaits(1, 1, 1, 7);
    runSeq("R4 sample seven", 2, 2, 7, 2);
  endtask

  task automatic testForcedOn();
    @(negedge clk) pwrMode = 2'b11; setWaits(5, 1, 2, 2);
    @(negedge clk);
    chk("R8 power on in idle", int'(pwrEn), 1);
    runSeq("R8 forced on", 0, 2, 2, 3);
    chk("R8 power held after", int'(pwrEn), 1);
    @(negedge clk) pwrMode = 2'b00;
  endtask

  task automatic testForcedOff();
    @(negedge clk) pwrMode = 2'b10; setWaits(2, 2, 2, 2);
    @(negedge clk) convReq = 1'b1;
    @(negedge clk) convReq = 1'b0;
    chk("R9 request ignored busy", int'(seqBusy), 0);
    chk("R9 power forced off", int'(pwrEn), 0);
    @(negedge clk) pwrMode = 2'b00;
    repeat (2) @(negedge clk);
    chk("R9 request not retained", int'(seqBusy), 0);
    // abort in the middle of a long settle phase
    setWaits(50, 2, 2, 2);
    convReq = 1'b1;
    @(negedge clk) convReq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 busy before abort", int'(seqBusy), 1);
    pwrMode = 2'b10;
    @(negedge clk);
    chk("R9 abort to idle", int'(seqBusy), 0);
    chk("R9 abort power", int'(pwrEn), 0);
    pwrMode = 2'b00;
    @(negedge clk);
  endtask

  task automatic testStandbyReq();
    int n = 0;
    pwrMode = 2'b00; setWaits(2, 1, 20, 1);
    @(negedge clk) convReq = 1'b1;
    @(negedge clk) convReq = 1'b0;
    convDone = 1'b1;
    while (!seqDone && n < 200) begin @(negedge clk); n++; end
    @(negedge clk) convDone = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 in standby", int'(seqBusy), 1);
    convReq = 1'b1;
    @(negedge clk) convReq = 1'b0;
    chk("R7 back to reset", int'(convRstN), 0);
    chk("R7 power kept", int'(pwrEn), 1);
    @(negedge clk);
    chk("R7 reset second cycle", int'(convRstN), 0);
    @(negedge clk);
    chk("R7 start follows", int'(convStart), 1);
    finishConv();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testAuto();
    testZero();
    testSampleEdges();
    testForcedOn();
    testForcedOff();
    testStandbyReq();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule